// File: doc/BRIEF.md
# Descriptor-Chain DMA Command Sequencer

This block walks a chain of 16-byte command descriptors held in system memory and carries each one out in turn. Software writes the address of the first descriptor into the command pointer, raises the run level, and the sequencer reads three header words, decodes the operation and then moves data, loads or stores a single word, or does nothing. It writes the channel status and the count of bytes left over into the fourth word of the descriptor. After that it either falls through to the next descriptor 16 bytes further on or jumps to the target address held in the descriptor.

Every descriptor carries three 2-bit qualifiers: one for the interrupt, one for the branch and one for the wait. Each qualifier is tested against a condition flag supplied by the surrounding channel register block. A stop descriptor parks the sequencer without advancing the pointer. Software can then rewrite that descriptor in place and pulse wake to extend the chain. Memory is reached through a plain word-wide request/acknowledge port. Descriptor words are kept in little-endian byte order, so they are byte-swapped on every fetch and every write-back.

Top module: `dma_cmd_seq`

## Requirements
- R1: While reset is asserted, and for the cycles it takes to release, `active_o`, `dead_o`, `irq_o`, `dev_valid_o` and `mem_req_o` are 0 and `cmdptr_o` is 0. A pulse on `cmdptr_ld_i` while the sequencer is idle or halted loads `cmdptr_i` into the command pointer.
- R2: A descriptor is fetched as three reads at pointer+0, +4 and +8. Each word is byte-swapped. In the swapped header word, bits [31:28] are the operation, [27:22] a tag, [21:20] the interrupt qualifier, [19:18] the branch qualifier, [17:16] the wait qualifier and [15:0] the byte count. Word 1 is the data address and word 2 is the branch target or quad data.
- R3: Operation 0 (transfer) reads ceil(count/4) raw words starting at the data address. Each word appears on `dev_data_o` with a one-cycle `dev_valid_o`. A count of 0 moves no words.
- R4: Raising `dev_stop_i` ends a transfer early. The residual written back is the requested count minus 4 bytes per word already moved.
- R5: When a descriptor that is not a stop completes, the sequencer writes the byte-swapped word {status[15:0], residual[15:0]} to pointer+12. Status is {run, pause, dead, active, tag[5:0], 6'b0}, which reads 16'h9000 for tag 0. The residual is 0 for operations other than transfer.
- R6: Without a taken branch, the next descriptor is fetched at the current pointer plus 16.
- R7: The qualifier codes are 0 never, 1 when the condition is set, 2 when the condition is clear, and 3 always. A branch whose qualifier is met loads the pointer from descriptor word 2. Quad operations never branch.
- R8: An interrupt qualifier that is met when the write-back completes gives a single one-cycle pulse on `irq_o`.
- R9: A wait qualifier that is met when the write-back completes keeps the sequencer active with no memory request until the qualifier is no longer met. The sequencer then fetches the next descriptor.
- R10: Operation 5 (load quad) reads the word at the data address and writes it, byte-swapped, into descriptor word 2. Operation 4 (store quad) writes the swapped-back value of descriptor word 2 to the data address.
- R11: Operation 7 (stop) clears `active_o`, leaves the pointer on the stop descriptor and performs no write-back. A `wake_i` pulse while halted re-fetches the descriptor at the pointer.
- R12: No new memory word is started while `pause_i` is high or `run_i` is low. A word already requested completes.
- R13: Operations 1-3 and 8-15 set `dead_o`, clear `active_o` and end all memory traffic until `run_i` is dropped, which clears `dead_o`.
- R14: Once `mem_req_o` is high, it and the address, write flag and write data hold steady until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Channel run level |
| pause_i | input | 1 | Hold between memory words |
| wake_i | input | 1 | Re-fetch pulse while halted |
| cmdptr_ld_i | input | 1 | Load command pointer |
| cmdptr_i | input | AW | New command pointer |
| int_cond_i | input | 1 | Interrupt selector condition |
| br_cond_i | input | 1 | Branch selector condition |
| wait_cond_i | input | 1 | Wait selector condition |
| dev_stop_i | input | 1 | Device ends the transfer early |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| dev_valid_o | output | 1 | Transfer word valid |
| dev_data_o | output | 32 | Transfer word |
| irq_o | output | 1 | Interrupt pulse |
| active_o | output | 1 | Sequencer is working through the chain |
| dead_o | output | 1 | Unknown operation met |
| cmdptr_o | output | AW | Current command pointer |

## Verification
The hardest state to reach from the ports is a halt on a stop descriptor followed by an in-place rewrite and a wake. The bench halts on a stop, overwrites that same descriptor in its memory model, pulses wake, and then checks that the write-back lands at the original pointer and that the chain ends one descriptor later. The other hard cases are an early transfer end and a wait hold. For the early end, a monitor raises the device stop right after the first delivered word, and the residual is derived from the number of words counted. For the wait hold, the wait condition is held high and the bench watches for several dozen cycles with no request while the block stays active.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_QLD, S_QLDWB,
    S_QST, S_WB, S_WAIT, S_HALT, S_DEAD
  } seq_state_e;

  localparam logic [3:0] OP_XFER   = 4'd0;
  localparam logic [3:0] OP_QSTORE = 4'd4;
  localparam logic [3:0] OP_QLOAD  = 4'd5;
  localparam logic [3:0] OP_NOP    = 4'd6;
  localparam logic [3:0] OP_STOP   = 4'd7;

  // qualifier codes: 0 never, 1 cond set, 2 cond clear, 3 always
  typedef struct packed {
    logic [3:0]  op;
    logic [5:0]  tag;
    logic [1:0]  intq;
    logic [1:0]  brq;
    logic [1:0]  waitq;
    logic [15:0] count;
  } desc_hdr_t;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/dma_qual_eval.sv
module dma_qual_eval (
  input  logic [1:0] qual_i,
  input  logic       cond_i,
  output logic       hit_o
);
  always_comb begin
    unique case (qual_i)
      2'd0:    hit_o = 1'b0;
      2'd1:    hit_o = cond_i;
      2'd2:    hit_o = ~cond_i;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          pause_i,
  input  logic          wake_i,
  input  logic          cmdptr_ld_i,
  input  logic [AW-1:0] cmdptr_i,
  input  logic          dev_stop_i,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          int_hit_i,
  input  logic          br_hit_i,
  input  logic          wait_hit_i,
  output logic [5:0]    quals_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic          dev_valid_o,
  output logic [31:0]   dev_data_o,
  output logic          irq_o,
  output logic          active_o,
  output logic          dead_o,
  output logic [AW-1:0] cmdptr_o
);
  localparam int DESC_BYTES = 16;
  localparam int WORD_BYTES = 4;
  localparam logic [15:0] WB16 = 16'(WORD_BYTES);

  seq_state_e state_q, state_d;
  desc_hdr_t  hdr_q, hdr_d;
  logic [AW-1:0] ptr_q, ptr_d, daddr_q, daddr_d, addr_q, addr_d;
  logic [31:0]   dep_q, dep_d, wdata_q, wdata_d, ddata_q, ddata_d;
  logic [15:0]   rem_q, rem_d;
  logic [1:0]    widx_q, widx_d;
  logic busy_q, busy_d, we_q, we_d, dv_q, dv_d, irq_q, irq_d, dead_q, dead_d;

  logic          ack, launch, l_we;
  logic [AW-1:0] l_addr;
  logic [31:0]   l_data, rd_sw, wb_word;
  logic          quad_op;

  assign ack     = busy_q & mem_ack_i;
  assign rd_sw   = bswap32(mem_rdata_i);
  assign quad_op = (hdr_q.op == OP_QLOAD) || (hdr_q.op == OP_QSTORE);
  assign wb_word = {run_i, pause_i, dead_q, 1'b1, hdr_q.tag, 6'b0, rem_q};

  // next-state logic
  always_comb begin
    state_d = state_q; hdr_d = hdr_q; ptr_d = ptr_q; daddr_d = daddr_q;
    dep_d = dep_q; rem_d = rem_q; widx_d = widx_q;
    busy_d = busy_q; we_d = we_q; addr_d = addr_q; wdata_d = wdata_q;
    ddata_d = ddata_q; dv_d = 1'b0; irq_d = 1'b0; dead_d = dead_q;
    launch = 1'b0; l_we = 1'b0; l_addr = addr_q; l_data = wdata_q;

    unique case (state_q)
      S_IDLE: begin
        dead_d = 1'b0;
        widx_d = 2'd0;
        if (cmdptr_ld_i)  ptr_d = cmdptr_i;
        else if (run_i)   state_d = S_FETCH;
      end
      S_HALT: begin
        widx_d = 2'd0;
        if (!run_i)            state_d = S_IDLE;
        else if (cmdptr_ld_i)  ptr_d = cmdptr_i;
        else if (wake_i)       state_d = S_FETCH;
      end
      S_FETCH: begin
        if (ack) begin
          busy_d = 1'b0;
          unique case (widx_q)
            2'd0:    hdr_d   = desc_hdr_t'(rd_sw);
            2'd1:    daddr_d = rd_sw[AW-1:0];
            default: dep_d   = rd_sw;
          endcase
          if (widx_q == 2'd2) state_d = S_DECODE;
          else                widx_d  = widx_q + 2'd1;
        end else if (!busy_q) begin
          if (!run_i)        state_d = S_IDLE;
          else if (!pause_i) begin
            launch = 1'b1;
            l_addr = ptr_q + AW'({widx_q, 2'b00});
          end
        end
      end
      S_DECODE: begin
        rem_d = 16'd0;
        unique case (hdr_q.op)
          OP_XFER:   begin rem_d = hdr_q.count; state_d = S_XFER; end
          OP_QLOAD:  state_d = S_QLD;
          OP_QSTORE: state_d = S_QST;
          OP_NOP:    state_d = S_WB;
          OP_STOP:   state_d = S_HALT;
          default:   begin dead_d = 1'b1; state_d = S_DEAD; end
        endcase
      end
      S_XFER: begin
        if (ack) begin
          busy_d  = 1'b0;
          dv_d    = 1'b1;
          ddata_d = mem_rdata_i;
          rem_d   = (rem_q > WB16) ? rem_q - WB16 : 16'd0;
          daddr_d = daddr_q + AW'(WORD_BYTES);
        end else if (!busy_q) begin
          if (rem_q == 16'd0 || dev_stop_i) state_d = S_WB;
          else if (!run_i)                  state_d = S_IDLE;
          else if (!pause_i) begin
            launch = 1'b1;
            l_addr = daddr_q;
          end
        end
      end
      S_QLD: begin
        if (ack) begin
          busy_d  = 1'b0;
          dep_d   = mem_rdata_i;
          state_d = S_QLDWB;
        end else if (!busy_q) begin
          if (!run_i)        state_d = S_IDLE;
          else if (!pause_i) begin
            launch = 1'b1;
            l_addr = daddr_q;
          end
        end
      end
      S_QLDWB: begin
        if (ack) begin
          busy_d  = 1'b0;
          state_d = S_WB;
        end else if (!busy_q) begin
          if (!run_i)        state_d = S_IDLE;
          else if (!pause_i) begin
            launch = 1'b1; l_we = 1'b1;
            l_addr = ptr_q + AW'(8);
            l_data = bswap32(dep_q);
          end
        end
      end
      S_QST: begin
        if (ack) begin
          busy_d  = 1'b0;
          state_d = S_WB;
        end else if (!busy_q) begin
          if (!run_i)        state_d = S_IDLE;
          else if (!pause_i) begin
            launch = 1'b1; l_we = 1'b1;
            l_addr = daddr_q;
            l_data = dep_q;
          end
        end
      end
      S_WB: begin
        if (ack) begin
          busy_d  = 1'b0;
          irq_d   = int_hit_i;
          widx_d  = 2'd0;
          ptr_d   = (br_hit_i && !quad_op) ? dep_q[AW-1:0]
                                           : ptr_q + AW'(DESC_BYTES);
          state_d = wait_hit_i ? S_WAIT : S_FETCH;
        end else if (!busy_q) begin
          if (!run_i)        state_d = S_IDLE;
          else if (!pause_i) begin
            launch = 1'b1; l_we = 1'b1;
            l_addr = ptr_q + AW'(12);
            l_data = bswap32(wb_word);
          end
        end
      end
      S_WAIT: begin
        if (!run_i)           state_d = S_IDLE;
        else if (!wait_hit_i) state_d = S_FETCH;
      end
      S_DEAD: begin
        if (!run_i) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    if (launch) begin
      busy_d  = 1'b1;
      we_d    = l_we;
      addr_d  = l_addr;
      wdata_d = l_data;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  hdr_q  <= '0;   ptr_q   <= '0;  daddr_q <= '0;
      dep_q   <= '0;      rem_q  <= '0;   widx_q  <= '0;  busy_q  <= 1'b0;
      we_q    <= 1'b0;    addr_q <= '0;   wdata_q <= '0;  ddata_q <= '0;
      dv_q    <= 1'b0;    irq_q  <= 1'b0; dead_q  <= 1'b0;
    end else begin
      state_q <= state_d; hdr_q  <= hdr_d; ptr_q   <= ptr_d;   daddr_q <= daddr_d;
      dep_q   <= dep_d;   rem_q  <= rem_d; widx_q  <= widx_d;  busy_q  <= busy_d;
      we_q    <= we_d;    addr_q <= addr_d; wdata_q <= wdata_d; ddata_q <= ddata_d;
      dv_q    <= dv_d;    irq_q  <= irq_d; dead_q  <= dead_d;
    end
  end

  assign quals_o     = {hdr_q.intq, hdr_q.brq, hdr_q.waitq};
  assign mem_req_o   = busy_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign dev_valid_o = dv_q;
  assign dev_data_o  = ddata_q;
  assign irq_o       = irq_q;
  assign dead_o      = dead_q;
  assign cmdptr_o    = ptr_q;
  assign active_o    = !(state_q inside {S_IDLE, S_HALT, S_DEAD});

endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          pause_i,
  input  logic          wake_i,
  input  logic          cmdptr_ld_i,
  input  logic [AW-1:0] cmdptr_i,
  input  logic          int_cond_i,
  input  logic          br_cond_i,
  input  logic          wait_cond_i,
  input  logic          dev_stop_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          dev_valid_o,
  output logic [31:0]   dev_data_o,
  output logic          irq_o,
  output logic          active_o,
  output logic          dead_o,
  output logic [AW-1:0] cmdptr_o
);
  localparam int NQUAL = 3;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [2*NQUAL-1:0] quals;
  logic [NQUAL-1:0] conds, hits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // index 0 wait, 1 branch, 2 interrupt
  assign conds = {int_cond_i, br_cond_i, wait_cond_i};

  for (genvar g = 0; g < NQUAL; g++) begin : g_qual
    dma_qual_eval u_qual (
      .qual_i (quals[2*g +: 2]),
      .cond_i (conds[g]),
      .hit_o  (hits[g])
    );
  end

  dma_seq_fsm #(.AW(AW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run_i       (run_i),
    .pause_i     (pause_i),
    .wake_i      (wake_i),
    .cmdptr_ld_i (cmdptr_ld_i),
    .cmdptr_i    (cmdptr_i),
    .dev_stop_i  (dev_stop_i),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .int_hit_i   (hits[2]),
    .br_hit_i    (hits[1]),
    .wait_hit_i  (hits[0]),
    .quals_o     (quals),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .dev_valid_o (dev_valid_o),
    .dev_data_o  (dev_data_o),
    .irq_o       (irq_o),
    .active_o    (active_o),
    .dead_o      (dead_o),
    .cmdptr_o    (cmdptr_o)
  );

endmodule

// File: rtl/dma_cmd_seq_chk.sv
module dma_cmd_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic          pause_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          dev_valid_o,
  input logic          irq_o,
  input logic          active_o,
  input logic          dead_o
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R14

  AST_DEV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o)); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> $past(run_i && !pause_i)); // R12

  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dead_o |-> !active_o && !mem_req_o); // R13

  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !mem_req_o); // R11

endmodule

bind dma_cmd_seq dma_cmd_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_cmd_seq_tb.sv
module dma_cmd_seq_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, pause_i = 1'b0, wake_i = 1'b0, cmdptr_ld_i = 1'b0;
  logic [AW-1:0] cmdptr_i = '0;
  logic int_cond_i = 1'b0, br_cond_i = 1'b0, wait_cond_i = 1'b0;
  logic dev_stop_i = 1'b0;
  logic stop_arm = 1'b0;
  logic ack_en = 1'b1;
  logic mem_req_o, mem_we_o, mem_ack_i, dev_valid_o, irq_o, active_o, dead_o;
  logic [AW-1:0] mem_addr_o, cmdptr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i, dev_data_o;

  always #5 clk = ~clk;

  dma_cmd_seq #(.AW(AW)) u_dut (.*);

  // memory model: 512 raw words
  logic [31:0] mem [0:511];
  logic        tb_we = 1'b0;
  logic [8:0]  tb_addr = '0;
  logic [31:0] tb_data = '0;
  assign mem_ack_i   = mem_req_o & ack_en;
  assign mem_rdata_i = mem[mem_addr_o[10:2]];
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o && mem_ack_i) mem[mem_addr_o[10:2]] <= mem_wdata_o;
    if (tb_we) mem[tb_addr] <= tb_data;
  end

  // observers
  int dv_cnt = 0, irq_cnt = 0, acc_n = 0;
  logic [31:0] dv_sum = '0;
  logic [31:0] acc_addr [0:15];
  always @(negedge clk) begin
    if (dev_valid_o) begin dv_cnt++; dv_sum += dev_data_o; end
    if (irq_o) irq_cnt++;
    if (mem_req_o && mem_ack_i) begin acc_addr[acc_n % 16] = mem_addr_o; acc_n++; end
    dev_stop_i <= stop_arm & (dev_stop_i | dev_valid_o);
  end

  int tests = 0, fails = 0;

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] hdr(input logic [3:0] op, input logic [1:0] iq,
                                      input logic [1:0] bq, input logic [1:0] wq,
                                      input logic [15:0] cnt);
    return {op, 6'b0, iq, bq, wq, cnt};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = a[10:2]; tb_data = d;
    tick(1);
    tb_we = 1'b0;
  endtask
  task automatic put_desc(input logic [31:0] a, input logic [31:0] h,
                          input logic [31:0] w1, input logic [31:0] w2);
    poke(a, sw(h)); poke(a + 4, sw(w1)); poke(a + 8, sw(w2));
    poke(a + 12, 32'h5EE5_5EE5);
  endtask
  task automatic launch(input logic [31:0] p);
    run_i = 1'b0; tick(2);
    cmdptr_ld_i = 1'b1; cmdptr_i = p; tick(1);
    cmdptr_ld_i = 1'b0; run_i = 1'b1; tick(2);
  endtask
  task automatic wait_halt(input string req);
    int n = 0;
    while (active_o && n < 3000) begin tick(1); n++; end
    check(n < 3000, req, 32'(n), 32'd0);
    tick(2);
  endtask

  typedef struct packed {
    logic [3:0] op; logic [1:0] iq; logic [1:0] bq; logic [1:0] wq;
    logic [15:0] cnt; logic ic; logic bc; logic [11:0] halt;
    logic [3:0] nw; logic irq;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{4'd0, 2'd0, 2'd0, 2'd0, 16'd8, 1'b0, 1'b0, 12'h110, 4'd2, 1'b0},
    '{4'd0, 2'd3, 2'd0, 2'd0, 16'd6, 1'b0, 1'b0, 12'h110, 4'd2, 1'b1},
    '{4'd6, 2'd0, 2'd3, 2'd0, 16'd0, 1'b0, 1'b0, 12'h200, 4'd0, 1'b0},
    '{4'd6, 2'd0, 2'd1, 2'd0, 16'd0, 1'b0, 1'b0, 12'h110, 4'd0, 1'b0},
    '{4'd6, 2'd1, 2'd2, 2'd0, 16'd0, 1'b1, 1'b0, 12'h200, 4'd0, 1'b1},
    '{4'd0, 2'd0, 2'd0, 2'd0, 16'd0, 1'b0, 1'b0, 12'h110, 4'd0, 1'b0},
    '{4'd6, 2'd2, 2'd1, 2'd0, 16'd0, 1'b0, 1'b1, 12'h200, 4'd1 - 4'd1, 1'b1}
  };

  localparam logic [31:0] STOP_H = 32'h7000_0000;
  localparam logic [31:0] WB_OK  = 32'h9000_0000;

  initial begin
    // R1: reset state
    tick(3);
    check(!active_o && !dead_o && !irq_o && !mem_req_o && !dev_valid_o, "R1",
          {27'd0, active_o, dead_o, irq_o, mem_req_o, dev_valid_o}, 32'd0);
    check(cmdptr_o == 32'd0, "R1", cmdptr_o, 32'd0);
    rst_n = 1'b1; tick(4);
    for (int i = 0; i < 16; i++) poke(32'h400 + 4 * i, 32'hA500_0000 + i);
    poke(32'h200, sw(STOP_H));

    // R14: request held while acknowledge is withheld
    put_desc(32'h100, hdr(4'd6, 2'd0, 2'd0, 2'd0, 16'd0), 32'h400, 32'h200);
    poke(32'h110, sw(STOP_H));
    ack_en = 1'b0;
    launch(32'h100); tick(3);
    check(mem_req_o && mem_addr_o == 32'h100, "R14", mem_addr_o, 32'h100);
    tick(4);
    check(mem_req_o && mem_addr_o == 32'h100 && !mem_we_o, "R14", mem_addr_o, 32'h100);
    check(cmdptr_o == 32'h100, "R1 pointer load", cmdptr_o, 32'h100);
    ack_en = 1'b1;
    wait_halt("R14");

    // table of single-descriptor runs
    for (int v = 0; v < 7; v++) begin
      int dv0, irq0, acc0;
      logic [31:0] sum0, exp_sum;
      put_desc(32'h100, hdr(VEC[v].op, VEC[v].iq, VEC[v].bq, VEC[v].wq, VEC[v].cnt),
               32'h400, 32'h200);
      poke(32'h110, sw(STOP_H));
      int_cond_i = VEC[v].ic; br_cond_i = VEC[v].bc;
      dv0 = dv_cnt; irq0 = irq_cnt; sum0 = dv_sum; acc0 = acc_n;
      launch(32'h100);
      wait_halt("R6");
      exp_sum = 32'd0;
      for (int k = 0; k < int'(VEC[v].nw); k++) exp_sum += 32'hA500_0000 + k;
      check(acc_addr[acc0 % 16] == 32'h100 && acc_addr[(acc0 + 1) % 16] == 32'h104
            && acc_addr[(acc0 + 2) % 16] == 32'h108, "R2 fetch order",
            acc_addr[(acc0 + 2) % 16], 32'h108);
      check(dv_cnt - dv0 == int'(VEC[v].nw), "R3 word count", 32'(dv_cnt - dv0),
            32'(VEC[v].nw));
      check(dv_sum - sum0 == exp_sum, "R3 data", dv_sum - sum0, exp_sum);
      check(mem[32'h10C >> 2] == sw(WB_OK), "R5 writeback", mem[32'h10C >> 2], sw(WB_OK));
      check(cmdptr_o == {20'd0, VEC[v].halt}, "R6 R7 next pointer", cmdptr_o,
            {20'd0, VEC[v].halt});
      check(irq_cnt - irq0 == int'(VEC[v].irq), "R8 interrupt", 32'(irq_cnt - irq0),
            32'(VEC[v].irq));
    end
    int_cond_i = 1'b0; br_cond_i = 1'b0;

    // R4: device ends the transfer early
    begin
      int dv0, moved;
      put_desc(32'h100, hdr(4'd0, 2'd0, 2'd0, 2'd0, 16'd16), 32'h400, 32'h200);
      poke(32'h110, sw(STOP_H));
      dv0 = dv_cnt; stop_arm = 1'b1;
      launch(32'h100);
      wait_halt("R4");
      stop_arm = 1'b0;
      moved = dv_cnt - dv0;
      check(moved >= 1 && moved < 4, "R4 words moved", 32'(moved), 32'd2);
      check(mem[32'h10C >> 2] == sw(WB_OK | 32'(16 - 4 * moved)), "R4 residual",
            mem[32'h10C >> 2], sw(WB_OK | 32'(16 - 4 * moved)));
    end

    // R9: wait qualifier holds the sequencer
    put_desc(32'h100, hdr(4'd6, 2'd0, 2'd0, 2'd1, 16'd0), 32'h400, 32'h200);
    poke(32'h110, sw(STOP_H));
    wait_cond_i = 1'b1;
    launch(32'h100); tick(40);
    check(active_o && !mem_req_o && cmdptr_o == 32'h110, "R9 hold", cmdptr_o, 32'h110);
    tick(20);
    check(active_o && !mem_req_o, "R9 hold", {31'd0, mem_req_o}, 32'd0);
    wait_cond_i = 1'b0;
    wait_halt("R9");
    check(cmdptr_o == 32'h110 && !active_o, "R9 release", cmdptr_o, 32'h110);

    // R12: pause prevents any memory word from starting
    put_desc(32'h100, hdr(4'd6, 2'd0, 2'd0, 2'd0, 16'd0), 32'h400, 32'h200);
    poke(32'h110, sw(STOP_H));
    pause_i = 1'b1;
    launch(32'h100); tick(20);
    check(active_o && !mem_req_o, "R12 paused", {31'd0, mem_req_o}, 32'd0);
    check(mem[32'h10C >> 2] == 32'h5EE5_5EE5, "R12 no writeback", mem[32'h10C >> 2],
          32'h5EE5_5EE5);
    pause_i = 1'b0;
    wait_halt("R12");
    check(mem[32'h10C >> 2] == sw(WB_OK), "R12 resumed", mem[32'h10C >> 2], sw(WB_OK));

    // R11: stop parks without write-back; wake re-fetches in place
    put_desc(32'h100, STOP_H, 32'h0, 32'h0);
    launch(32'h100);
    wait_halt("R11");
    check(cmdptr_o == 32'h100, "R11 halt pointer", cmdptr_o, 32'h100);
    check(mem[32'h10C >> 2] == 32'h5EE5_5EE5, "R11 no writeback", mem[32'h10C >> 2],
          32'h5EE5_5EE5);
    put_desc(32'h100, hdr(4'd6, 2'd0, 2'd0, 2'd0, 16'd0), 32'h400, 32'h200);
    poke(32'h110, sw(STOP_H));
    wake_i = 1'b1; tick(1); wake_i = 1'b0; tick(1);
    check(active_o, "R11 wake", {31'd0, active_o}, 32'd1);
    wait_halt("R11");
    check(cmdptr_o == 32'h110, "R11 after wake", cmdptr_o, 32'h110);
    check(mem[32'h10C >> 2] == sw(WB_OK), "R11 writeback", mem[32'h10C >> 2], sw(WB_OK));

    // R10: load quad then store quad
    put_desc(32'h100, hdr(4'd5, 2'd0, 2'd3, 2'd0, 16'd0), 32'h400, 32'h0);
    put_desc(32'h110, hdr(4'd4, 2'd0, 2'd3, 2'd0, 16'd0), 32'h404, 32'h1234_5678);
    poke(32'h120, sw(STOP_H));
    launch(32'h100);
    wait_halt("R10");
    check(mem[32'h108 >> 2] == sw(32'hA500_0000), "R10 load quad", mem[32'h108 >> 2],
          sw(32'hA500_0000));
    check(mem[32'h404 >> 2] == 32'h1234_5678, "R10 store quad", mem[32'h404 >> 2],
          32'h1234_5678);
    check(cmdptr_o == 32'h120, "R7 quad never branches", cmdptr_o, 32'h120);
    check(mem[32'h11C >> 2] == sw(WB_OK), "R5 quad writeback", mem[32'h11C >> 2], sw(WB_OK));

    // R13: unknown operation
    put_desc(32'h100, hdr(4'd9, 2'd0, 2'd0, 2'd0, 16'd4), 32'h400, 32'h200);
    launch(32'h100);
    wait_halt("R13");
    tick(10);
    check(dead_o && !active_o && !mem_req_o, "R13 dead", {31'd0, dead_o}, 32'd1);
    check(mem[32'h10C >> 2] == 32'h5EE5_5EE5, "R13 no writeback", mem[32'h10C >> 2],
          32'h5EE5_5EE5);
    run_i = 1'b0; tick(3);
    check(!dead_o, "R13 cleared", {31'd0, dead_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule